// File: doc/BRIEF.md
# Two-Operand Addressing Mode Decoder

This block sits at the front of the execute path of a small 16-bit CPU. It accepts a two-operand instruction word and splits it into its fields. It sorts each operand into one of eight addressing kinds. Two register numbers have a special meaning: register 0, the program counter, gives PC-relative and immediate operands, and registers 2 and 3 give absolute addresses and constants. When an operand needs an extension word, the block reads that word from memory and builds the final source value or address and the destination address.

A caller pulses `start` while the block is idle. With the pulse it presents the instruction word, the address of that word, and the current contents of the registers the word names. The block then issues up to two reads on a memory port whose data returns in the same cycle. It pulses `done` when all its outputs are valid, and it holds them until the next accepted `start`. The operand kinds use these codes: 0 register, 1 indexed, 2 indirect, 3 autoincrement, 4 PC-relative, 5 absolute, 6 immediate, 7 generated constant.

Top module: `two_op_addr_decoder`

## Requirements
- R1: On an accepted start, the instruction word is split as follows: opcode from bits 15:12, source register from 11:8, destination mode bit from bit 7, byte flag from bit 6, source mode from 5:4 and destination register from 3:0. These fields appear on `opcode`, `src_reg`, `ad_bit`, `byte_op`, `as_bits` and `dst_reg`.
- R2: A source register other than 0, 2 and 3 takes a general mode from its mode bits. Mode 00 is register (code 0, operand = register value, `src_mem`=0). Mode 01 is indexed (code 1, operand = register value + extension word, `src_mem`=1). Mode 10 is indirect (code 2, operand = register value, `src_mem`=1). Register 0 with mode 00 or 10 and register 2 with mode 00 also follow these rules.
- R3: Autoincrement (mode 11 with a general register, code 3) gives operand = register value and `src_mem`=1. It sets `autoinc_en` and gives `autoinc_val` = register value + 1 when the byte flag is 1, or + 2 when it is 0. Every other source mode leaves `autoinc_en` at 0.
- R4: Source register 0 with mode 01, or destination register 0 with the destination mode bit at 1, is PC-relative (code 4). Its address is the address of its own extension word plus that word.
- R5: Source register 0 with mode 11 is immediate (code 6). The operand is the extension word, with `src_mem`=0.
- R6: Source register 2 with mode 01, or destination register 2 with the destination mode bit at 1, is absolute (code 5). The address is the extension word itself.
- R7: Register 2 gives the constant 4 for mode 10 and 8 for mode 11. Register 3 gives 0, 1, 2 and all-ones for modes 00, 01, 10 and 11. These have code 7 and `src_mem`=0, and they use no extension word.
- R8: Extension words are read from the instruction address + 2, then + 4. The source's word is read before the destination's.
- R9: `done` is high for exactly one cycle, and it comes 1 + (number of extension words) cycles after the clock edge that accepts `start`. `instr_len` then reports 1, 2 or 3 words.
- R10: A `start` that arrives while `busy` is high is ignored. The running decode completes unchanged, and no new decode begins.
- R11: After reset, `busy`, `done`, `mem_rd_en` and `autoinc_en` are 0.
- R12: A destination mode bit of 0 is register mode (code 0, `dst_operand` = destination register value, `dst_mem`=0). A mode bit of 1 with a register other than 0 and 2 is indexed (code 1, address = register value + extension word, `dst_mem`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin decoding `instr` (taken only when idle) |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | Address of the instruction word |
| src_reg_val | input | 16 | Contents of the register in bits 11:8 |
| dst_reg_val | input | 16 | Contents of the register in bits 3:0 |
| mem_rd_en | output | 1 | Extension word read strobe |
| mem_addr | output | 16 | Extension word address |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the strobe |
| opcode | output | 4 | Opcode field |
| src_reg | output | 4 | Source register number |
| dst_reg | output | 4 | Destination register number |
| byte_op | output | 1 | Byte flag |
| as_bits | output | 2 | Source mode bits |
| ad_bit | output | 1 | Destination mode bit |
| src_mode | output | 3 | Source kind code |
| dst_mode | output | 3 | Destination kind code |
| src_operand | output | 16 | Source value or source address |
| src_mem | output | 1 | `src_operand` is an address |
| dst_operand | output | 16 | Destination address, or register value in register mode |
| dst_mem | output | 1 | `dst_operand` is an address |
| autoinc_en | output | 1 | Source register must be written back |
| autoinc_val | output | 16 | Incremented source register value |
| busy | output | 1 | A decode is in progress |
| done | output | 1 | Outputs valid strobe |
| instr_len | output | 2 | Instruction length in words |

## Verification
Directed words cover the three-word move of an immediate to an absolute address, an immediate to a register, PC-relative on both sides, and each constant from registers 2 and 3. Together they separate the special register cases from the general modes that share the same mode bits. Seeded random words have their register fields biased toward 0, 2 and 3, so that every kind on both sides meets in every mix of 0, 1 and 2 extension words. The reads are then ordered and counted against the expected length, which shows whether the source word is placed before the destination word. Some runs also pulse `start` again while the block is busy. Such a run must finish with the values of the first word and return to idle.

// File: rtl/tod_pkg.sv
// Shared types for the two-operand addressing decoder.
// Assumes a 16-bit instruction word with the field layout below.
package tod_pkg;

    // Operand kind codes, visible on the top-level mode outputs.
    typedef enum logic [2:0] {
        AM_REG       = 3'd0,
        AM_INDEXED   = 3'd1,
        AM_INDIRECT  = 3'd2,
        AM_AUTOINC   = 3'd3,
        AM_PCREL     = 3'd4,
        AM_ABSOLUTE  = 3'd5,
        AM_IMMEDIATE = 3'd6,
        AM_CONST     = 3'd7
    } amode_e;

    // Instruction word layout, most significant field first.
    typedef struct packed {
        logic [3:0] opc;
        logic [3:0] sreg;
        logic       ad;
        logic       bw;
        logic [1:0] as_m;
        logic [3:0] dreg;
    } iword_s;

    localparam int          IWORD_W = 16;
    localparam logic [3:0]  RN_PC   = 4'd0;
    localparam logic [3:0]  RN_SR   = 4'd2;
    localparam logic [3:0]  RN_CG   = 4'd3;

endpackage

// File: rtl/tod_classify.sv
// Purely combinational operand classifier.
// Maps register numbers and mode bits to an operand kind. It flags whether
// each operand consumes an extension word and yields the generated constant.
// Assumes: register 0 is the PC, 2 the status register, 3 the constant source.
module tod_classify
    import tod_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [3:0]        sreg,
    input  logic [1:0]        as_m,
    input  logic [3:0]        dreg,
    input  logic              ad,
    output amode_e            src_mode,
    output amode_e            dst_mode,
    output logic              src_ext,
    output logic              dst_ext,
    output logic [WORD_W-1:0] cg_val
);

    // Source kind: special registers first, then the general mode table.
    always_comb begin
        src_mode = AM_REG;
        cg_val   = '0;
        unique case (as_m)
            2'b00: begin
                if (sreg == RN_CG) begin
                    src_mode = AM_CONST;
                    cg_val   = '0;
                end else begin
                    src_mode = AM_REG;
                end
            end
            2'b01: begin
                if (sreg == RN_PC) begin
                    src_mode = AM_PCREL;
                end else if (sreg == RN_SR) begin
                    src_mode = AM_ABSOLUTE;
                end else if (sreg == RN_CG) begin
                    src_mode = AM_CONST;
                    cg_val   = WORD_W'(1);
                end else begin
                    src_mode = AM_INDEXED;
                end
            end
            2'b10: begin
                if (sreg == RN_SR) begin
                    src_mode = AM_CONST;
                    cg_val   = WORD_W'(4);
                end else if (sreg == RN_CG) begin
                    src_mode = AM_CONST;
                    cg_val   = WORD_W'(2);
                end else begin
                    src_mode = AM_INDIRECT;
                end
            end
            default: begin
                if (sreg == RN_PC) begin
                    src_mode = AM_IMMEDIATE;
                end else if (sreg == RN_SR) begin
                    src_mode = AM_CONST;
                    cg_val   = WORD_W'(8);
                end else if (sreg == RN_CG) begin
                    src_mode = AM_CONST;
                    cg_val   = '1;
                end else begin
                    src_mode = AM_AUTOINC;
                end
            end
        endcase
    end

    // Destination kind: one mode bit, two special registers.
    always_comb begin
        if (!ad)                dst_mode = AM_REG;
        else if (dreg == RN_PC) dst_mode = AM_PCREL;
        else if (dreg == RN_SR) dst_mode = AM_ABSOLUTE;
        else                    dst_mode = AM_INDEXED;
    end

    // Extension word usage per operand.
    always_comb begin
        src_ext = (src_mode == AM_INDEXED)  || (src_mode == AM_PCREL) ||
                  (src_mode == AM_ABSOLUTE) || (src_mode == AM_IMMEDIATE);
        dst_ext = ad;
    end

endmodule

// File: rtl/tod_fetch_seq.sv
// Extension word fetch sequencer.
// Accepts a start when idle. It reads the source extension word, then the
// destination one (each only if needed), and ends with a one-cycle done.
// Assumes the read port returns data in the same cycle as the strobe.
module tod_fetch_seq #(
    parameter int ADDR_W  = 16,
    parameter int PC_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              need_src,
    input  logic              need_dst,
    input  logic [ADDR_W-1:0] pc_base,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_src,
    output logic              rd_dst,
    output logic [1:0]        len
);

    typedef enum logic [1:0] {ST_IDLE, ST_SRC, ST_DST, ST_FIN} st_e;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

    st_e               st_q;
    logic              need_dst_q;
    logic [ADDR_W-1:0] pc_q;

    assign accept  = start && (st_q == ST_IDLE);
    assign busy    = (st_q != ST_IDLE);
    assign done    = (st_q == ST_FIN);
    assign rd_src  = (st_q == ST_SRC);
    assign rd_dst  = (st_q == ST_DST);
    assign rd_en   = rd_src || rd_dst;
    assign rd_addr = pc_q;

    // State, fetch pointer and length bookkeeping for one instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            need_dst_q <= 1'b0;
            pc_q       <= '0;
            len        <= 2'd0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (accept) begin
                    pc_q       <= pc_base + STEP;
                    need_dst_q <= need_dst;
                    len        <= 2'd1 + 2'(need_src) + 2'(need_dst);
                    if (need_src)      st_q <= ST_SRC;
                    else if (need_dst) st_q <= ST_DST;
                    else               st_q <= ST_FIN;
                end
                ST_SRC: begin
                    pc_q <= pc_q + STEP;
                    st_q <= need_dst_q ? ST_DST : ST_FIN;
                end
                ST_DST: begin
                    pc_q <= pc_q + STEP;
                    st_q <= ST_FIN;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tod_operand_res.sv
// Operand resolver.
// Fixes the operands that need no memory word at accept time. It completes
// the indexed, PC-relative, absolute and immediate operands when their
// extension word is read. Assumes the register values are valid at accept.
module tod_operand_res
    import tod_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              rd_src,
    input  logic              rd_dst,
    input  logic [WORD_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    input  amode_e            src_mode_in,
    input  amode_e            dst_mode_in,
    input  logic [WORD_W-1:0] cg_val,
    input  logic              byte_mode,
    input  logic [WORD_W-1:0] src_reg_val,
    input  logic [WORD_W-1:0] dst_reg_val,
    output amode_e            src_mode_q,
    output amode_e            dst_mode_q,
    output logic [WORD_W-1:0] src_operand,
    output logic              src_mem,
    output logic [WORD_W-1:0] dst_operand,
    output logic              dst_mem,
    output logic              ainc_en,
    output logic [WORD_W-1:0] ainc_val
);

    logic [WORD_W-1:0] src_base_q;
    logic [WORD_W-1:0] dst_base_q;
    logic [WORD_W-1:0] step;

    assign step = byte_mode ? WORD_W'(1) : WORD_W'(2);

    // Source side: seed at accept, finish on the source word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_mode_q  <= AM_REG;
            src_operand <= '0;
            src_mem     <= 1'b0;
            src_base_q  <= '0;
            ainc_en     <= 1'b0;
            ainc_val    <= '0;
        end else if (accept) begin
            src_mode_q <= src_mode_in;
            src_base_q <= src_reg_val;
            ainc_en    <= (src_mode_in == AM_AUTOINC);
            ainc_val   <= (src_mode_in == AM_AUTOINC) ? src_reg_val + step : '0;
            unique case (src_mode_in)
                AM_REG:      begin src_operand <= src_reg_val; src_mem <= 1'b0; end
                AM_INDIRECT,
                AM_AUTOINC:  begin src_operand <= src_reg_val; src_mem <= 1'b1; end
                AM_CONST:    begin src_operand <= cg_val;      src_mem <= 1'b0; end
                AM_IMMEDIATE: begin src_operand <= '0;         src_mem <= 1'b0; end
                default:     begin src_operand <= '0;          src_mem <= 1'b1; end
            endcase
        end else if (rd_src) begin
            unique case (src_mode_q)
                AM_INDEXED:  src_operand <= src_base_q + rd_data;
                AM_PCREL:    src_operand <= rd_addr + rd_data;
                default:     src_operand <= rd_data;
            endcase
        end
    end

    // Destination side: seed at accept, finish on the destination word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_mode_q  <= AM_REG;
            dst_operand <= '0;
            dst_mem     <= 1'b0;
            dst_base_q  <= '0;
        end else if (accept) begin
            dst_mode_q  <= dst_mode_in;
            dst_base_q  <= dst_reg_val;
            dst_mem     <= (dst_mode_in != AM_REG);
            dst_operand <= (dst_mode_in == AM_REG) ? dst_reg_val : '0;
        end else if (rd_dst) begin
            unique case (dst_mode_q)
                AM_INDEXED:  dst_operand <= dst_base_q + rd_data;
                AM_PCREL:    dst_operand <= rd_addr + rd_data;
                default:     dst_operand <= rd_data;
            endcase
        end
    end

endmodule

// File: rtl/two_op_addr_decoder.sv
// Top of the two-operand addressing decoder.
// Captures the instruction at an accepted start and classifies both operands.
// Sequences up to two extension word reads and presents the resolved operands
// with a done strobe. Assumes the caller supplies both register values with start.
module two_op_addr_decoder
    import tod_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int PC_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] src_reg_val,
    input  logic [WORD_W-1:0] dst_reg_val,
    output logic              mem_rd_en,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [3:0]        opcode,
    output logic [3:0]        src_reg,
    output logic [3:0]        dst_reg,
    output logic              byte_op,
    output logic [1:0]        as_bits,
    output logic              ad_bit,
    output logic [2:0]        src_mode,
    output logic [2:0]        dst_mode,
    output logic [WORD_W-1:0] src_operand,
    output logic              src_mem,
    output logic [WORD_W-1:0] dst_operand,
    output logic              dst_mem,
    output logic              autoinc_en,
    output logic [WORD_W-1:0] autoinc_val,
    output logic              busy,
    output logic              done,
    output logic [1:0]        instr_len
);

    iword_s            live_w;
    iword_s            instr_q;
    amode_e            cls_src, cls_dst, res_src, res_dst;
    logic              cls_src_ext, cls_dst_ext;
    logic [WORD_W-1:0] cls_cg;
    logic              accept, rd_src, rd_dst;

    assign live_w = instr;

    // Hold the accepted instruction word for the field outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      instr_q <= '0;
        else if (accept) instr_q <= live_w;
    end

    assign opcode  = instr_q.opc;
    assign src_reg = instr_q.sreg;
    assign dst_reg = instr_q.dreg;
    assign byte_op = instr_q.bw;
    assign as_bits = instr_q.as_m;
    assign ad_bit  = instr_q.ad;

    tod_classify #(.WORD_W(WORD_W)) u_cls (
        .sreg     (live_w.sreg),
        .as_m     (live_w.as_m),
        .dreg     (live_w.dreg),
        .ad       (live_w.ad),
        .src_mode (cls_src),
        .dst_mode (cls_dst),
        .src_ext  (cls_src_ext),
        .dst_ext  (cls_dst_ext),
        .cg_val   (cls_cg)
    );

    tod_fetch_seq #(.ADDR_W(WORD_W), .PC_STEP(PC_STEP)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .need_src (cls_src_ext),
        .need_dst (cls_dst_ext),
        .pc_base  (pc_in),
        .accept   (accept),
        .busy     (busy),
        .done     (done),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_addr),
        .rd_src   (rd_src),
        .rd_dst   (rd_dst),
        .len      (instr_len)
    );

    tod_operand_res #(.WORD_W(WORD_W)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .rd_src      (rd_src),
        .rd_dst      (rd_dst),
        .rd_addr     (mem_addr),
        .rd_data     (mem_rdata),
        .src_mode_in (cls_src),
        .dst_mode_in (cls_dst),
        .cg_val      (cls_cg),
        .byte_mode   (live_w.bw),
        .src_reg_val (src_reg_val),
        .dst_reg_val (dst_reg_val),
        .src_mode_q  (res_src),
        .dst_mode_q  (res_dst),
        .src_operand (src_operand),
        .src_mem     (src_mem),
        .dst_operand (dst_operand),
        .dst_mem     (dst_mem),
        .ainc_en     (autoinc_en),
        .ainc_val    (autoinc_val)
    );

    assign src_mode = res_src;
    assign dst_mode = res_dst;

endmodule

// File: rtl/tod_checker.sv
// Protocol checker for the two-operand addressing decoder, bound to the top.
// Counts the extension reads of each instruction and relates them to the
// reported length, the read addresses and the done strobe.
module tod_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_rd_en,
    input logic [WORD_W-1:0] mem_addr,
    input logic [1:0]        instr_len,
    input logic [2:0]        src_mode,
    input logic              autoinc_en
);

    logic [1:0] rd_cnt;

    // Reads issued since the last done.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_cnt <= 2'd0;
        else if (done)      rd_cnt <= 2'd0;
        else if (mem_rd_en) rd_cnt <= rd_cnt + 2'd1;
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_len_matches_reads: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (instr_len == rd_cnt + 2'd1));

    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + WORD_W'(2)));

    a_r11_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

    a_r3_autoinc_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (done && autoinc_en) |-> (src_mode == 3'd3));

    a_r10_launch_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind two_op_addr_decoder tod_checker #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .instr_len  (instr_len),
    .src_mode   (src_mode),
    .autoinc_en (autoinc_en)
);

// File: tb/two_op_addr_decoder_tb.sv
`timescale 1ns/1ps
// Bench for the two-operand addressing decoder: directed corner words plus
// seeded random words, compared with a reference model written from the brief.
module two_op_addr_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0, pc_in = '0, src_reg_val = '0, dst_reg_val = '0;
    logic        mem_rd_en;
    logic [15:0] mem_addr, mem_rdata;
    logic [3:0]  opcode, src_reg, dst_reg;
    logic        byte_op, ad_bit, src_mem, dst_mem, autoinc_en, busy, done;
    logic [1:0]  as_bits, instr_len;
    logic [2:0]  src_mode, dst_mode;
    logic [15:0] src_operand, dst_operand, autoinc_val;

    logic [15:0] mem [0:127];
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:1]];

    two_op_addr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
        .src_reg_val(src_reg_val), .dst_reg_val(dst_reg_val),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .opcode(opcode), .src_reg(src_reg), .dst_reg(dst_reg), .byte_op(byte_op),
        .as_bits(as_bits), .ad_bit(ad_bit), .src_mode(src_mode), .dst_mode(dst_mode),
        .src_operand(src_operand), .src_mem(src_mem), .dst_operand(dst_operand),
        .dst_mem(dst_mem), .autoinc_en(autoinc_en), .autoinc_val(autoinc_val),
        .busy(busy), .done(done), .instr_len(instr_len)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    task automatic model(input logic [15:0] ins, pc, sv, dv, e0, e1,
                         output logic [2:0] sm, output logic [15:0] sop, output bit smem,
                         output logic [2:0] dm, output logic [15:0] dop, output bit dmem,
                         output bit ae, output logic [15:0] av, output int len,
                         output string stag, output string dtag);
        logic [1:0] a;
        logic [3:0] s, d;
        bit sx;
        logic [15:0] dw, dwa;
        a = ins[5:4]; s = ins[11:8]; d = ins[3:0];
        sx = 0; ae = 0; av = 0; smem = 0; sop = 0; sm = 0;
        if (s == 4'd3) begin
            sm = 7; stag = "R7";
            sop = (a == 2'd0) ? 16'd0 : (a == 2'd1) ? 16'd1 : (a == 2'd2) ? 16'd2 : 16'hFFFF;
        end else if (s == 4'd2 && a == 2'd2) begin sm = 7; sop = 16'd4; stag = "R7";
        end else if (s == 4'd2 && a == 2'd3) begin sm = 7; sop = 16'd8; stag = "R7";
        end else if (s == 4'd0 && a == 2'd3) begin sm = 6; sop = e0; sx = 1; stag = "R5";
        end else if (s == 4'd0 && a == 2'd1) begin
            sm = 4; sop = pc + 16'd2 + e0; smem = 1; sx = 1; stag = "R4";
        end else if (s == 4'd2 && a == 2'd1) begin sm = 5; sop = e0; smem = 1; sx = 1; stag = "R6";
        end else begin
            stag = "R2";
            case (a)
                2'd0: begin sm = 0; sop = sv; end
                2'd1: begin sm = 1; sop = sv + e0; smem = 1; sx = 1; end
                2'd2: begin sm = 2; sop = sv; smem = 1; end
                default: begin
                    sm = 3; sop = sv; smem = 1; ae = 1; stag = "R3";
                    av = sv + (ins[6] ? 16'd1 : 16'd2);
                end
            endcase
        end
        dw  = sx ? e1 : e0;
        dwa = pc + 16'd2 + (sx ? 16'd2 : 16'd0);
        if (!ins[7])           begin dm = 0; dop = dv;        dmem = 0; dtag = "R12"; end
        else if (d == 4'd0)    begin dm = 4; dop = dwa + dw;  dmem = 1; dtag = "R4";  end
        else if (d == 4'd2)    begin dm = 5; dop = dw;        dmem = 1; dtag = "R6";  end
        else                   begin dm = 1; dop = dv + dw;   dmem = 1; dtag = "R12"; end
        len = 1 + int'(sx) + int'(ins[7]);
    endtask

    task automatic run_one(input logic [15:0] ins, pc, sv, dv, e0, e1, input bit poke);
        logic [2:0] sm, dm;
        logic [15:0] sop, dop, av;
        bit smem, dmem, ae, got;
        int len, cyc, nrd;
        string stag, dtag;
        logic [15:0] ra [2];
        mem[(pc + 16'd2) >> 1] = e0;
        mem[(pc + 16'd4) >> 1] = e1;
        model(ins, pc, sv, dv, e0, e1, sm, sop, smem, dm, dop, dmem, ae, av, len, stag, dtag);
        ra[0] = '0; ra[1] = '0;
        @(negedge clk);
        instr = ins; pc_in = pc; src_reg_val = sv; dst_reg_val = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cyc = 1; nrd = 0; got = 0;
        while (cyc < 12) begin
            if (mem_rd_en) begin
                if (nrd < 2) ra[nrd] = mem_addr;
                nrd++;
            end
            if (poke && cyc == 1) begin
                start = 1'b1; instr = ~ins; pc_in = pc ^ 16'h0040;
                src_reg_val = ~sv; dst_reg_val = ~dv;
            end
            if (done) begin got = 1; break; end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        start = 1'b0;
        chk(got, "R9", "done seen", 32'(got), 32'd1);
        chk(cyc == len, "R9", "done cycle", 32'(cyc), 32'(len));
        chk(instr_len == 2'(len), "R9", "instr_len", 32'(instr_len), 32'(len));
        chk(nrd == len - 1, "R8", "read count", 32'(nrd), 32'(len - 1));
        if (nrd >= 1) chk(ra[0] == pc + 16'd2, "R8", "first read addr", 32'(ra[0]), 32'(pc + 16'd2));
        if (nrd >= 2) chk(ra[1] == pc + 16'd4, "R8", "second read addr", 32'(ra[1]), 32'(pc + 16'd4));
        chk({opcode, src_reg, ad_bit, byte_op, as_bits, dst_reg} == ins, "R1", "fields",
            32'({opcode, src_reg, ad_bit, byte_op, as_bits, dst_reg}), 32'(ins));
        chk(src_mode == sm, stag, "src_mode", 32'(src_mode), 32'(sm));
        chk(src_operand == sop, stag, "src_operand", 32'(src_operand), 32'(sop));
        chk(src_mem == smem, stag, "src_mem", 32'(src_mem), 32'(smem));
        chk(dst_mode == dm, dtag, "dst_mode", 32'(dst_mode), 32'(dm));
        chk(dst_operand == dop, dtag, "dst_operand", 32'(dst_operand), 32'(dop));
        chk(dst_mem == dmem, dtag, "dst_mem", 32'(dst_mem), 32'(dmem));
        chk(autoinc_en == ae, "R3", "autoinc_en", 32'(autoinc_en), 32'(ae));
        if (ae) chk(autoinc_val == av, "R3", "autoinc_val", 32'(autoinc_val), 32'(av));
        if (poke) begin
            @(negedge clk);
            chk(!busy, "R10", "busy after ignored start", 32'(busy), 32'd0);
            chk(src_operand == sop && dst_operand == dop, "R10", "operands held",
                32'({src_operand, dst_operand}), 32'({sop, dop}));
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [3:0] pick [3];
        void'($urandom(32'h5EED_0430));
        for (int i = 0; i < 128; i++) mem[i] = '0;
        pick[0] = 4'd0; pick[1] = 4'd2; pick[2] = 4'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle state after reset
        chk(!busy && !done && !mem_rd_en && !autoinc_en, "R11", "reset outputs",
            32'({busy, done, mem_rd_en, autoinc_en}), 32'd0);

        // R5/R6/R8: immediate to absolute, three words, source word first
        run_one(16'h40B2, 16'h0010, 16'h1111, 16'h2222, 16'h5A80, 16'h0120, 0);
        // R5/R12: immediate to register, two words
        run_one(16'h4031, 16'h0020, 16'h0000, 16'hBEEF, 16'h03FF, 16'h0000, 0);
        // R4: PC-relative on both sides
        run_one(16'h4090, 16'h0030, 16'h0000, 16'h0000, 16'h0100, 16'h0204, 0);
        // R7: every constant from registers 2 and 3
        run_one(16'h4325, 16'h0040, 16'h9999, 16'h7777, 16'hAAAA, 16'hBBBB, 0);
        run_one(16'h4315, 16'h0040, 16'h9999, 16'h7777, 16'hAAAA, 16'hBBBB, 0);
        run_one(16'h4335, 16'h0040, 16'h9999, 16'h7777, 16'hAAAA, 16'hBBBB, 0);
        run_one(16'h4305, 16'h0040, 16'h9999, 16'h7777, 16'hAAAA, 16'hBBBB, 0);
        run_one(16'h4225, 16'h0040, 16'h9999, 16'h7777, 16'hAAAA, 16'hBBBB, 0);
        run_one(16'h4235, 16'h0040, 16'h9999, 16'h7777, 16'hAAAA, 16'hBBBB, 0);
        // R3: autoincrement byte and word
        run_one(16'h4576, 16'h0050, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 0);
        run_one(16'h4536, 16'h0050, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 0);
        // R6/R12: absolute source, indexed destination
        run_one(16'h4297, 16'h0060, 16'h0000, 16'h8000, 16'h0200, 16'h0010, 0);
        // R10: stray start while busy, zero and two extension words
        run_one(16'h4506, 16'h0070, 16'h3333, 16'h4444, 16'h0000, 16'h0000, 1);
        run_one(16'h4595, 16'h0070, 16'h3333, 16'h4444, 16'h0011, 16'h0022, 1);

        // Seeded random words biased toward the special registers.
        for (int i = 0; i < 300; i++) begin
            w = 16'($urandom);
            if ($urandom % 2 == 0) w[11:8] = pick[$urandom % 3];
            if ($urandom % 2 == 0) w[3:0]  = pick[$urandom % 3];
            run_one(w, 16'(($urandom % 120) * 2), 16'($urandom), 16'($urandom),
                    16'($urandom), 16'($urandom), (i % 7) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule